// File: doc/BRIEF.md
# Core-Memory Slot Sequencer

This block times one core-memory cycle as a row of six equal slots, each a fixed number of clocks long so that a slot matches one microsecond of the system clock. It raises the address-load and read strobes in the first slot. After the second slot it stalls until the memory reports that the read is complete. It allows the data register to be loaded only in the third and fourth slots and issues the regenerating write in the fourth slot. The fifth and sixth slots give the write time to finish.

The same slot grid also drives the program-counter update cycle. In that cycle the first slot captures the branch decision, the third slot loads the modified counter, and the fifth slot samples the pending-switch line from the interrupt controller and clears the overflow indicator and the instruction register. If no switch is pending, the sixth slot copies the data register's top bit into the overflow indicator and the block hands over to an instruction fetch. If a switch is pending, the whole cycle runs again in a modified form that addresses the interrupting program's counter. This repeats for as long as the controller keeps reporting a higher-priority program.

Top module: `slot_sequencer`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `slot` is 0 and every strobe is 0 until a start is accepted.
- R2: A `start` seen while idle begins slot 1 on the next clock. `addr_load` and `rd_cmd` are high for the first clock of slot 1. Each slot lasts CLKS_PER_SLOT clocks and `slot` shows its number (1 to 6). A `start` seen while busy is ignored.
- R3: When slot 2 ends, the block holds with `slot` = 2 and `mem_wait` = 1 and samples `rd_done` once per clock. On the clock after `rd_done` is seen high, slot 3 begins. `rd_done` has no effect outside the hold.
- R4: `wr_cmd` is high only for the first clock of slot 4, once on every pass.
- R5: `data_load` is high only in the first clock of slot 3 on every pass, and in the first clock of slot 4 on the first pass of a counter-update cycle. It is never high in any other slot.
- R6: If `rd_done` stays low for TIMEOUT held clocks in a row, `mem_timeout` goes to 1 on the next clock. It stays at 1 until the next accepted start, and the hold continues.
- R7: In a counter-update cycle (`pc_cycle` = 1 at start), `branch_latch` is high for the first clock of slot 1 on the first pass, and `branch_taken` takes the value of `branch_cond` from that clock. `ctr_update` is high for the first clock of slot 3 on every pass.
- R8: In a counter-update cycle, `ovf_clear` and `ireg_clear` are high for the first clock of slot 5, and `hi_pending` is sampled on that clock.
- R9: In a counter-update cycle with no switch sampled, `ovf_from_msb` is high for the first clock of slot 6, and `done` and `fetch_next` are high for the last clock of slot 6. After that the block is idle.
- R10: If `hi_pending` was sampled high, the cycle restarts at slot 1 with `irq_fetch` = 1. On that pass `branch_latch` stays low, `branch_taken` is cleared, and slot 4 does not load the data register. This repeats once for each pass on which the switch is sampled high.
- R11: A plain memory cycle (`pc_cycle` = 0) produces none of `ctr_update`, `ovf_clear`, `ireg_clear`, `ovf_from_msb`, `branch_latch` or `fetch_next`. It ends with `done` in the last clock of slot 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a cycle |
| pc_cycle | input | 1 | Cycle is a counter-update cycle (sampled with start) |
| rd_done | input | 1 | Memory read complete |
| hi_pending | input | 1 | Higher-priority program pending |
| branch_cond | input | 1 | Branch condition met |
| slot | output | 3 | Current slot number, 0 when idle |
| busy | output | 1 | A cycle is in progress |
| addr_load | output | 1 | Load the memory address register |
| rd_cmd | output | 1 | Memory read command |
| data_load | output | 1 | Load the memory data register |
| wr_cmd | output | 1 | Memory write (regenerate) command |
| branch_latch | output | 1 | Capture the branch decision |
| branch_taken | output | 1 | Captured branch decision |
| ctr_update | output | 1 | Load the modified program counter |
| ovf_clear | output | 1 | Clear the overflow indicator |
| ireg_clear | output | 1 | Clear the instruction register |
| ovf_from_msb | output | 1 | Load the overflow indicator from the data register's top bit |
| irq_fetch | output | 1 | Pass is fetching the interrupting program's counter |
| mem_wait | output | 1 | Holding for read complete |
| mem_timeout | output | 1 | Read complete overdue |
| done | output | 1 | Last clock of the cycle |
| fetch_next | output | 1 | Next cycle is an instruction fetch |

## Verification
A wrong slot number or sub-slot count moves a strobe to another clock. The per-clock comparison reports this on the first clock where the strobe is early or late. A hold flag stuck at 1 or 0 shows within one clock of the end of slot 2, as a wrong `mem_wait` or an early slot 3. A lost switch flag or repeat flag shows only later, at slot 6 (a missing repeat, or `done` where none is due) or at slot 4 of the repeated pass (a stray `data_load`). For this reason the bench also counts the strobes of each whole cycle against the numbers that the requirements fix.

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
  parameter int CLKS_PER_SLOT = 100,
  parameter int TIMEOUT       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pc_cycle,
  input  logic       rd_done,
  input  logic       hi_pending,
  input  logic       branch_cond,
  output logic [2:0] slot,
  output logic       busy,
  output logic       addr_load,
  output logic       rd_cmd,
  output logic       data_load,
  output logic       wr_cmd,
  output logic       branch_latch,
  output logic       branch_taken,
  output logic       ctr_update,
  output logic       ovf_clear,
  output logic       ireg_clear,
  output logic       ovf_from_msb,
  output logic       irq_fetch,
  output logic       mem_wait,
  output logic       mem_timeout,
  output logic       done,
  output logic       fetch_next
);
  localparam int SW = $clog2(CLKS_PER_SLOT) + 1;
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(CLKS_PER_SLOT - 1);
  localparam logic [TW-1:0] WAIT_MAX = TW'(TIMEOUT);

  logic          busy_q, wait_q, pc_q, redo_q, sw_q, br_q, to_q;
  logic [2:0]    slot_q;
  logic [SW-1:0] sub_q;
  logic [TW-1:0] wcnt_q;

  wire first = busy_q && !wait_q && (sub_q == '0);
  wire last  = busy_q && !wait_q && (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      pc_q   <= 1'b0;
      redo_q <= 1'b0;
      sw_q   <= 1'b0;
      br_q   <= 1'b0;
      to_q   <= 1'b0;
      slot_q <= 3'd0;
      sub_q  <= '0;
      wcnt_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        slot_q <= 3'd1;
        sub_q  <= '0;
        wait_q <= 1'b0;
        pc_q   <= pc_cycle;
        redo_q <= 1'b0;
        sw_q   <= 1'b0;
        br_q   <= 1'b0;
        to_q   <= 1'b0;
        wcnt_q <= '0;
      end
    end else if (wait_q) begin
      if (rd_done) begin
        wait_q <= 1'b0;
        slot_q <= 3'd3;
        sub_q  <= '0;
      end else if (wcnt_q != WAIT_MAX) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (wcnt_q == WAIT_MAX - 1'b1) to_q <= 1'b1;
      end
    end else begin
      if (first && slot_q == 3'd1 && pc_q) br_q <= redo_q ? 1'b0 : branch_cond;
      if (first && slot_q == 3'd5 && pc_q) sw_q <= hi_pending;
      if (last) begin
        sub_q <= '0;
        case (slot_q)
          3'd2: begin
            wait_q <= 1'b1;
            wcnt_q <= '0;
          end
          3'd6: begin
            if (pc_q && sw_q) begin
              slot_q <= 3'd1;
              redo_q <= 1'b1;
              sw_q   <= 1'b0;
            end else begin
              busy_q <= 1'b0;
              slot_q <= 3'd0;
            end
          end
          default: slot_q <= slot_q + 3'd1;
        endcase
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign slot         = slot_q;
  assign busy         = busy_q;
  assign mem_wait     = wait_q;
  assign mem_timeout  = to_q;
  assign branch_taken = br_q;
  assign irq_fetch    = busy_q && redo_q;
  assign addr_load    = first && slot_q == 3'd1;
  assign rd_cmd       = first && slot_q == 3'd1;
  assign wr_cmd       = first && slot_q == 3'd4;
  assign data_load    = first && (slot_q == 3'd3 || (slot_q == 3'd4 && pc_q && !redo_q));
  assign branch_latch = first && slot_q == 3'd1 && pc_q && !redo_q;
  assign ctr_update   = first && slot_q == 3'd3 && pc_q;
  assign ovf_clear    = first && slot_q == 3'd5 && pc_q;
  assign ireg_clear   = first && slot_q == 3'd5 && pc_q;
  assign ovf_from_msb = first && slot_q == 3'd6 && pc_q && !sw_q;
  assign done         = last && slot_q == 3'd6 && !(pc_q && sw_q);
  assign fetch_next   = done && pc_q;
endmodule

// File: rtl/slot_sequencer_chk.sv
module slot_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       rd_done,
  input logic [2:0] slot,
  input logic       busy,
  input logic       addr_load,
  input logic       data_load,
  input logic       wr_cmd,
  input logic       branch_latch,
  input logic       irq_fetch,
  input logic       mem_wait,
  input logic       mem_timeout,
  input logic       done
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !addr_load && !wr_cmd && !data_load && !done && slot == 3'd0);

  a_r2_start_slot1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && slot == 3'd1 && addr_load);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wait && !rd_done |=> mem_wait && slot == 3'd2);

  a_r3_resume: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wait && rd_done |=> !mem_wait && slot == 3'd3 && data_load);

  a_r4_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |-> slot == 3'd4 && !mem_wait);

  a_r5_load_window: assert property (@(posedge clk) disable iff (!rst_n)
    data_load |-> (slot == 3'd3 || slot == 3'd4));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mem_timeout && !(!busy && start) |=> mem_timeout);

  a_r10_no_relatch: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fetch |-> !branch_latch);
endmodule

bind slot_sequencer slot_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_done(rd_done),
  .slot(slot), .busy(busy), .addr_load(addr_load), .data_load(data_load),
  .wr_cmd(wr_cmd), .branch_latch(branch_latch), .irq_fetch(irq_fetch),
  .mem_wait(mem_wait), .mem_timeout(mem_timeout), .done(done)
);

// File: tb/slot_sequencer_bench.sv
module slot_sequencer_bench;
  localparam int C  = 3;
  localparam int TO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pc_cycle = 1'b0, rd_done = 1'b0, hi_pending = 1'b0, branch_cond = 1'b0;
  logic [2:0] slot;
  logic busy, addr_load, rd_cmd, data_load, wr_cmd, branch_latch, branch_taken;
  logic ctr_update, ovf_clear, ireg_clear, ovf_from_msb, irq_fetch, mem_wait, mem_timeout;
  logic done, fetch_next;

  always #5 clk = ~clk;

  slot_sequencer #(.CLKS_PER_SLOT(C), .TIMEOUT(TO)) u_slot_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_cycle(pc_cycle), .rd_done(rd_done),
    .hi_pending(hi_pending), .branch_cond(branch_cond), .slot(slot), .busy(busy),
    .addr_load(addr_load), .rd_cmd(rd_cmd), .data_load(data_load), .wr_cmd(wr_cmd),
    .branch_latch(branch_latch), .branch_taken(branch_taken), .ctr_update(ctr_update),
    .ovf_clear(ovf_clear), .ireg_clear(ireg_clear), .ovf_from_msb(ovf_from_msb),
    .irq_fetch(irq_fetch), .mem_wait(mem_wait), .mem_timeout(mem_timeout),
    .done(done), .fetch_next(fetch_next));

  int checks = 0, errors = 0;
  int m_busy = 0, m_slot = 0, m_sub = 0, m_wait = 0, m_wcnt = 0;
  int m_pc = 0, m_redo = 0, m_sw = 0, m_br = 0, m_to = 0;
  int rd_delay = 0, rd_noise = 0, held = 0, nsw = 0, strobes5 = 0;
  int n_dl, n_ctr, n_done, n_fetch, n_msb, n_bl, n_wr, n_passes, n_ovf;

  task automatic cmp(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_slot = 0; m_sub = 0; m_wait = 0; m_wcnt = 0;
      m_pc = 0; m_redo = 0; m_sw = 0; m_br = 0; m_to = 0;
    end else if (m_busy == 0) begin
      if (start) begin
        m_busy = 1; m_slot = 1; m_sub = 0; m_wait = 0; m_pc = int'(pc_cycle);
        m_redo = 0; m_sw = 0; m_br = 0; m_to = 0; m_wcnt = 0;
      end
    end else if (m_wait == 1) begin
      if (rd_done) begin m_wait = 0; m_slot = 3; m_sub = 0; end
      else if (m_wcnt < TO) begin m_wcnt++; if (m_wcnt == TO) m_to = 1; end
    end else begin
      if (m_sub == 0 && m_slot == 1 && m_pc == 1) m_br = m_redo ? 0 : int'(branch_cond);
      if (m_sub == 0 && m_slot == 5 && m_pc == 1) m_sw = int'(hi_pending);
      if (m_sub == C - 1) begin
        m_sub = 0;
        if (m_slot == 2) begin m_wait = 1; m_wcnt = 0; end
        else if (m_slot == 6) begin
          if (m_pc == 1 && m_sw == 1) begin m_slot = 1; m_redo = 1; m_sw = 0; end
          else begin m_busy = 0; m_slot = 0; end
        end else m_slot++;
      end else m_sub++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit f = m_busy == 1 && m_wait == 0 && m_sub == 0;
      automatic bit l = m_busy == 1 && m_wait == 0 && m_sub == C - 1;
      automatic bit e_done = l && m_slot == 6 && !(m_pc == 1 && m_sw == 1);
      cmp("R2", "slot", int'(slot), m_slot);
      cmp("R2", "busy", int'(busy), m_busy);
      cmp("R2", "addr_load", int'(addr_load), int'(f && m_slot == 1));
      cmp("R2", "rd_cmd", int'(rd_cmd), int'(f && m_slot == 1));
      cmp("R3", "mem_wait", int'(mem_wait), m_wait);
      cmp("R4", "wr_cmd", int'(wr_cmd), int'(f && m_slot == 4));
      cmp("R5", "data_load", int'(data_load),
          int'(f && (m_slot == 3 || (m_slot == 4 && m_pc == 1 && m_redo == 0))));
      cmp("R6", "mem_timeout", int'(mem_timeout), m_to);
      cmp("R7", "branch_latch", int'(branch_latch), int'(f && m_slot == 1 && m_pc == 1 && m_redo == 0));
      cmp("R7", "branch_taken", int'(branch_taken), m_br);
      cmp("R7", "ctr_update", int'(ctr_update), int'(f && m_slot == 3 && m_pc == 1));
      cmp("R8", "ovf_clear", int'(ovf_clear), int'(f && m_slot == 5 && m_pc == 1));
      cmp("R8", "ireg_clear", int'(ireg_clear), int'(f && m_slot == 5 && m_pc == 1));
      cmp("R9", "ovf_from_msb", int'(ovf_from_msb), int'(f && m_slot == 6 && m_pc == 1 && m_sw == 0));
      cmp("R9", "done", int'(done), int'(e_done));
      cmp("R9", "fetch_next", int'(fetch_next), int'(e_done && m_pc == 1));
      cmp("R10", "irq_fetch", int'(irq_fetch), int'(m_busy == 1 && m_redo == 1));
      if (data_load) n_dl++;
      if (ctr_update) n_ctr++;
      if (done) n_done++;
      if (fetch_next) n_fetch++;
      if (ovf_from_msb) n_msb++;
      if (branch_latch) n_bl++;
      if (wr_cmd) n_wr++;
      if (addr_load) n_passes++;
      if (ovf_clear) n_ovf++;
      if (mem_wait) held++; else held = 0;
      rd_done = mem_wait ? (held > rd_delay) : (rd_noise != 0);
      if (ovf_clear) strobes5++;
      hi_pending = (strobes5 <= nsw);
    end
  end

  task automatic clear_counts();
    n_dl = 0; n_ctr = 0; n_done = 0; n_fetch = 0; n_msb = 0;
    n_bl = 0; n_wr = 0; n_passes = 0; n_ovf = 0; strobes5 = 0;
  endtask

  task automatic run(input bit pc, input bit br, input int sw, input int dly);
    @(negedge clk);
    clear_counts();
    nsw = sw; rd_delay = dly; pc_cycle = pc; branch_cond = br; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_counts();
    repeat (3) @(negedge clk);
    cmp("R1", "reset busy", int'(busy), 0);
    cmp("R1", "reset slot", int'(slot), 0);
    cmp("R1", "reset strobes", int'({addr_load, rd_cmd, data_load, wr_cmd, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1", "idle after reset", int'(busy), 0);

    run(1'b0, 1'b1, 0, 2);
    cmp("R11", "mem ctr_update", n_ctr, 0);
    cmp("R11", "mem fetch_next", n_fetch, 0);
    cmp("R11", "mem branch_latch", n_bl, 0);
    cmp("R11", "mem ovf_clear", n_ovf, 0);
    cmp("R11", "mem done", n_done, 1);
    cmp("R5", "mem data_load count", n_dl, 1);

    run(1'b1, 1'b1, 0, 0);
    cmp("R7", "branch kept", int'(branch_taken), 1);
    cmp("R9", "pc fetch_next", n_fetch, 1);
    cmp("R9", "pc ovf_from_msb", n_msb, 1);
    cmp("R5", "pc data_load count", n_dl, 2);

    run(1'b1, 1'b1, 1, 1);
    cmp("R10", "one switch passes", n_passes, 2);
    cmp("R10", "one switch data_load", n_dl, 3);
    cmp("R10", "branch cleared", int'(branch_taken), 0);
    cmp("R10", "one switch branch_latch", n_bl, 1);
    cmp("R4", "one switch wr_cmd", n_wr, 2);

    run(1'b1, 1'b0, 2, 3);
    cmp("R10", "two switch passes", n_passes, 3);
    cmp("R7", "two switch ctr_update", n_ctr, 3);
    cmp("R9", "two switch done", n_done, 1);

    rd_noise = 1;
    run(1'b0, 1'b0, 0, 0);
    rd_noise = 0;
    cmp("R3", "noise passes", n_passes, 1);

    run(1'b0, 1'b0, 0, 20);
    cmp("R6", "timeout set", int'(mem_timeout), 1);
    run(1'b0, 1'b0, 0, 15);
    cmp("R6", "timeout cleared, not reached", int'(mem_timeout), 0);

    @(negedge clk);
    clear_counts();
    nsw = 0; rd_delay = 4; pc_cycle = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (C + 1) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cmp("R2", "start while busy ignored", int'(slot), 2);
    while (busy) @(negedge clk);
    cmp("R2", "single cycle", n_passes, 1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule